// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds or subtracts two 64-bit words treated as a vector of independent integer lanes. One run-time select splits the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. The carry chain is cut at every lane edge, so no lane can see a neighbour's carry. Subtraction adds the inverted second operand and puts the extra one in at the least significant bit of each lane.

Each lane is read as signed or unsigned and reports its own overflow. With saturation off, a lane wraps modulo its width. With saturation on, a lane that overflows is clamped to the limit of its range on the side it overflowed. The result and the flags leave through one output register, so a media pipeline can place the block as a single stage.

Top module: `psimd_sat_adder`

## Requirements
- R1: While `rst_n` is low the result and the flag vector are all zero.
- R2: `lane_sel_i` gives the lane width: 0 selects 8-bit lanes, 1 selects 16-bit lanes, 2 selects 32-bit lanes, and 3 acts the same as 2. Lane k holds bits [k*W +: W], and no carry or borrow passes from one lane into the next.
- R3: The result and flags for the inputs sampled at one rising clock edge appear on the outputs after that edge and stay there until the next edge.
- R4: With `sub_i` = 1 every lane computes opa − opb, made as opa + ~opb + 1 with the one added at that lane's lowest bit. With `sub_i` = 0 every lane computes opa + opb.
- R5: With `signed_i` = 1 a lane overflows on add only when both operands have the same sign and the result sign differs from it. On subtract it overflows only when the operands' signs differ and the result sign differs from opa's sign.
- R6: With `signed_i` = 0 a lane overflows on add when the sum carries out of the lane, and on subtract when opb > opa (borrow).
- R7: `ovf_o` bit k flags lane k. Bits at or above the number of lanes in the selected mode are zero.
- R8: With `sat_i` = 0 each lane returns its result modulo 2^W, and its flag is still reported.
- R9: With `sat_i` = 1 and signed lanes, an overflowing lane returns 0x7F…F when the true result is too large and 0x80…0 when it is too small.
- R10: With `sat_i` = 1 and unsigned lanes, an overflowing add returns all ones and an overflowing subtract returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 64 | First operand vector |
| opb_i | input | 64 | Second operand vector |
| lane_sel_i | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32 bits) |
| sub_i | input | 1 | 1 = subtract opb from opa, 0 = add |
| signed_i | input | 1 | 1 = lanes are two's complement, 0 = unsigned |
| sat_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| res_o | output | 64 | Registered lane results |
| ovf_o | output | 8 | Registered per-lane overflow flags |

## Verification
The bench builds the block with its default parameters: a 64-bit word cut into 8-bit segments. That gives eight segments, so all three lane widths and the spare select code can be reached. Against a lane-by-lane integer model it drives operands built from each width's extremes, 0x7F…, 0x80…, zero and all ones, and mixes them with random words. This reaches positive and negative signed clamps, carry-out and borrow clamps, and carries that would cross a lane edge if the chain were not cut.

// File: rtl/psa_pkg.sv
package psa_pkg;

    typedef enum logic [1:0] {
        LANE_B8   = 2'd0,
        LANE_B16  = 2'd1,
        LANE_B32  = 2'd2,
        LANE_B32X = 2'd3
    } lane_sel_e;

    // Number of base segments that form one lane in the given mode.
    function automatic int unsigned segs_per_lane(input lane_sel_e m);
        unique case (m)
            LANE_B8:  return 1;
            LANE_B16: return 2;
            default:  return 4;
        endcase
    endfunction

endpackage

// File: rtl/psa_lane_map.sv
module psa_lane_map
    import psa_pkg::*;
#(
    parameter int NSEG = 8,
    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  lane_sel_e          mode,
    output logic [NSEG-1:0]    first_seg,
    output logic [IDX_W-1:0]   span_m1
);

    always_comb begin
        int unsigned spl;
        spl     = segs_per_lane(mode);
        span_m1 = IDX_W'(spl - 1);
        for (int i = 0; i < NSEG; i++) begin
            first_seg[i] = ((i & int'(spl - 1)) == 0);
        end
    end

endmodule

// File: rtl/psa_chain.sv
module psa_chain #(
    parameter int SEG_W = 8,
    parameter int NSEG  = 8,
    localparam int WORD_W = SEG_W * NSEG
) (
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic              sub,
    input  logic [NSEG-1:0]   first_seg,
    output logic [WORD_W-1:0] sum,
    output logic [NSEG-1:0]   seg_cout
);

    // One ripple through all segments; at a lane start the carry
    // from below is dropped and the subtract increment enters instead.
    always_comb begin
        logic             ripple;
        logic             cin;
        logic [SEG_W:0]   part;
        logic [SEG_W-1:0] b_eff;
        ripple = 1'b0;
        for (int i = 0; i < NSEG; i++) begin
            cin   = first_seg[i] ? sub : ripple;
            b_eff = opb[i*SEG_W +: SEG_W] ^ {SEG_W{sub}};
            part  = {1'b0, opa[i*SEG_W +: SEG_W]} + {1'b0, b_eff}
                  + {{SEG_W{1'b0}}, cin};
            sum[i*SEG_W +: SEG_W] = part[SEG_W-1:0];
            seg_cout[i]           = part[SEG_W];
            ripple                = part[SEG_W];
        end
    end

endmodule

// File: rtl/psa_sat.sv
module psa_sat #(
    parameter int SEG_W = 8,
    parameter int NSEG  = 8,
    localparam int WORD_W = SEG_W * NSEG,
    localparam int IDX_W  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [WORD_W-1:0] sum,
    input  logic [NSEG-1:0]   seg_cout,
    input  logic [IDX_W-1:0]  span_m1,
    input  logic              sub,
    input  logic              sgn,
    input  logic              sat,
    output logic [WORD_W-1:0] res,
    output logic [NSEG-1:0]   ovf_lane
);

    logic [NSEG-1:0] ovf_seg;   // overflow if this segment ended a lane
    logic [NSEG-1:0] high_seg;  // overflow direction is towards the top

    always_comb begin
        logic a_s, b_s, r_s;
        for (int i = 0; i < NSEG; i++) begin
            a_s = opa[i*SEG_W + SEG_W - 1];
            b_s = opb[i*SEG_W + SEG_W - 1] ^ sub;
            r_s = sum[i*SEG_W + SEG_W - 1];
            if (sgn) begin
                ovf_seg[i]  = (a_s == b_s) && (r_s != a_s);
                high_seg[i] = ~a_s;
            end else begin
                ovf_seg[i]  = sub ? ~seg_cout[i] : seg_cout[i];
                high_seg[i] = ~sub;
            end
        end
    end

    always_comb begin
        int               last;
        logic [SEG_W-1:0] clamp;
        for (int i = 0; i < NSEG; i++) begin
            last  = i | int'(span_m1);
            clamp = {SEG_W{high_seg[last]}};
            if (sgn && (i == last)) begin
                clamp[SEG_W-1] = ~clamp[SEG_W-1];
            end
            res[i*SEG_W +: SEG_W] = (sat && ovf_seg[last]) ? clamp
                                                           : sum[i*SEG_W +: SEG_W];
        end
    end

    always_comb begin
        int idx;
        for (int k = 0; k < NSEG; k++) begin
            idx         = k * (int'(span_m1) + 1) + int'(span_m1);
            ovf_lane[k] = (idx < NSEG) ? ovf_seg[idx] : 1'b0;
        end
    end

endmodule

// File: rtl/psimd_sat_adder.sv
module psimd_sat_adder
    import psa_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int SEG_W  = 8,
    localparam int NSEG  = WORD_W / SEG_W,
    localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [1:0]        lane_sel_i,
    input  logic              sub_i,
    input  logic              signed_i,
    input  logic              sat_i,
    output logic [WORD_W-1:0] res_o,
    output logic [NSEG-1:0]   ovf_o
);

    lane_sel_e         mode;
    logic [NSEG-1:0]   first_seg;
    logic [IDX_W-1:0]  span_m1;
    logic [WORD_W-1:0] raw_sum;
    logic [NSEG-1:0]   seg_cout;
    logic [WORD_W-1:0] res_d;
    logic [NSEG-1:0]   ovf_d;

    assign mode = lane_sel_e'(lane_sel_i);

    psa_lane_map #(.NSEG(NSEG)) u_map (
        .mode      (mode),
        .first_seg (first_seg),
        .span_m1   (span_m1)
    );

    psa_chain #(.SEG_W(SEG_W), .NSEG(NSEG)) u_chain (
        .opa       (opa_i),
        .opb       (opb_i),
        .sub       (sub_i),
        .first_seg (first_seg),
        .sum       (raw_sum),
        .seg_cout  (seg_cout)
    );

    psa_sat #(.SEG_W(SEG_W), .NSEG(NSEG)) u_sat (
        .opa       (opa_i),
        .opb       (opb_i),
        .sum       (raw_sum),
        .seg_cout  (seg_cout),
        .span_m1   (span_m1),
        .sub       (sub_i),
        .sgn       (signed_i),
        .sat       (sat_i),
        .res       (res_d),
        .ovf_lane  (ovf_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_o <= '0;
            ovf_o <= '0;
        end else begin
            res_o <= res_d;
            ovf_o <= ovf_d;
        end
    end

    // Reference slices for the lowest two base lanes, used only by checks.
    logic [SEG_W-1:0] chk_wrap0;
    logic [SEG_W-1:0] chk_wrap1;
    assign chk_wrap0 = opa_i[SEG_W-1:0] + opb_i[SEG_W-1:0];
    assign chk_wrap1 = opa_i[2*SEG_W-1:SEG_W] + opb_i[2*SEG_W-1:SEG_W];

    // R7: flags above the active lane count stay clear
    a_r7_unused_flags_16: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == 2'd1) |=> (ovf_o[NSEG-1:NSEG/2] == '0));

    a_r7_unused_flags_32: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i[1]) |=> (ovf_o[NSEG-1:NSEG/4] == '0));

    // R5: opposite-sign signed add never overflows
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == 2'd0 && signed_i && !sub_i
         && (opa_i[SEG_W-1] != opb_i[SEG_W-1])) |=> !ovf_o[0]);

    // R10: unsigned saturating add clamps to all ones
    a_r10_usat_add_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == 2'd0 && !signed_i && !sub_i && sat_i)
        |=> (!ovf_o[0] || res_o[SEG_W-1:0] == '1));

    // R8: wrapping add in narrow lanes is modulo the lane width
    a_r8_wrap_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == 2'd0 && !sub_i && !sat_i)
        |=> (res_o[SEG_W-1:0] == $past(chk_wrap0)));

    // R2: lane 1 is untouched by lane 0's carry
    a_r2_lane1_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == 2'd0 && !sub_i && !sat_i)
        |=> (res_o[2*SEG_W-1:SEG_W] == $past(chk_wrap1)));

endmodule

// File: tb/psimd_sat_adder_tb.sv
module psimd_sat_adder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [1:0]  lsel = '0;
    logic        sub = 1'b0;
    logic        sgn = 1'b0;
    logic        sat = 1'b0;
    logic [63:0] res;
    logic [7:0]  ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [71:0] last_exp = '0;

    always #10 clk = ~clk;

    psimd_sat_adder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .opa_i      (opa),
        .opb_i      (opb),
        .lane_sel_i (lsel),
        .sub_i      (sub),
        .signed_i   (sgn),
        .sat_i      (sat),
        .res_o      (res),
        .ovf_o      (ovf)
    );

    // Lane-by-lane integer model: returns {flags, result}.
    function automatic logic [71:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [1:0] ls, input logic s,
                                          input logic sg, input logic st);
        int          w;
        int          n;
        longint      mask, va, vb, r, lo, hi;
        logic [63:0] rv;
        logic [7:0]  fl;
        w  = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        n  = 64 / w;
        mask = (64'sd1 <<< w) - 1;
        rv = '0;
        fl = '0;
        for (int k = 0; k < n; k++) begin
            va = longint'(a >> (k*w)) & mask;
            vb = longint'(b >> (k*w)) & mask;
            if (sg) begin
                if (va >= (64'sd1 <<< (w-1))) va = va - (64'sd1 <<< w);
                if (vb >= (64'sd1 <<< (w-1))) vb = vb - (64'sd1 <<< w);
                lo = -(64'sd1 <<< (w-1));
                hi = (64'sd1 <<< (w-1)) - 1;
            end else begin
                lo = 0;
                hi = mask;
            end
            r = s ? va - vb : va + vb;
            if (r < lo || r > hi) begin
                fl[k] = 1'b1;
                if (st) r = (r < lo) ? lo : hi;
            end
            rv = rv | (64'(r & mask) << (k*w));
        end
        return {fl, rv};
    endfunction

    task automatic check(input logic [71:0] exp, input string tag);
        total++;
        if (res !== exp[63:0] || ovf !== exp[71:64]) begin
            bad++;
            $display("FAIL %s: res=%h ovf=%b expected res=%h ovf=%b",
                     tag, res, ovf, exp[63:0], exp[71:64]);
        end
    endtask

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] ls,
                         input logic s, input logic sg, input logic st, input string tag);
        logic [71:0] exp;
        @(negedge clk);
        opa = a; opb = b; lsel = ls; sub = s; sgn = sg; sat = st;
        exp = model(a, b, ls, s, sg, st);
        #2;
        check(last_exp, "R3 output held before edge");
        @(negedge clk);
        check(exp, tag);
        last_exp = exp;
    endtask

    function automatic logic [63:0] pick(input int unsigned sel);
        case (sel % 10)
            0: return 64'h0;
            1: return '1;
            2: return 64'h7F7F_7F7F_7F7F_7F7F;
            3: return 64'h8080_8080_8080_8080;
            4: return 64'h7FFF_7FFF_7FFF_7FFF;
            5: return 64'h8000_8000_8000_8000;
            6: return 64'h7FFF_FFFF_7FFF_FFFF;
            7: return 64'h8000_0000_8000_0000;
            8: return 64'h0101_0101_0101_0101;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(72'h0, "R1 reset state");
        rst_n = 1'b1;

        // R2: carries stop at lane edges in every width
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 0, 0, 0, "R2 8-bit isolation");
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd1, 0, 0, 0, "R2 16-bit carry");
        apply(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd2, 0, 0, 0, "R2 32-bit isolation");
        apply(64'h0000_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 0, 0, "R2 code 3 as 32-bit");
        // R4: subtract with per-lane increment
        apply(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 2'd0, 1, 0, 0, "R4 8-bit subtract wrap");
        apply(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd1, 1, 0, 0, "R4 16-bit subtract");
        // R5 / R8: signed overflow flagged, result wraps
        apply(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 0, "R5 R8 signed add wrap");
        apply(64'h8000_8000_8000_8000, 64'h0001_0001_0001_0001, 2'd1, 1, 1, 0, "R5 signed sub wrap");
        apply(64'h7F80_7F80_7F80_7F80, 64'h80FF_80FF_80FF_80FF, 2'd0, 0, 1, 0, "R5 mixed signs");
        // R6: unsigned carry-out and borrow
        apply(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0002, 2'd2, 0, 0, 0, "R6 unsigned carry");
        apply(64'h0000_0001_0000_0005, 64'h0000_0002_0000_0005, 2'd2, 1, 0, 0, "R6 unsigned borrow");
        // R9: signed clamps in both directions
        apply(64'h7FFF_8000_7FFF_8000, 64'h0001_FFFF_0001_FFFF, 2'd1, 0, 1, 1, "R9 signed clamp");
        apply(64'h7FFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 2'd2, 1, 1, 1, "R9 signed sub clamp");
        // R10: unsigned clamps
        apply(64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_0000_0000, 2'd0, 0, 0, 1, "R10 unsigned add clamp");
        apply(64'h0010_0010_0010_0010, 64'h0020_0005_0020_0005, 2'd1, 1, 0, 1, "R10 unsigned sub clamp");
        // R7: upper flags clear with every lane overflowing
        apply('1, '1, 2'd2, 0, 0, 0, "R7 unused flags clear");

        for (int i = 0; i < 600; i++) begin
            apply(pick($urandom), pick($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), "R2 R4 R8 R9 R10 random corners");
        end

        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check(72'h0, "R1 reset clears outputs");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R3: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule